// File: doc/BRIEF.md
# Conversion Result Register Bank

This block holds the latest conversion result for every converter channel that has a result register: external channels 0 through 15 and one internal channel at index 29. The converter side presents each finished conversion as a one-cycle write strobe that carries a 5-bit channel index and a 16-bit value. The block stores the value in that channel's register and sets the channel's valid flag. If the previous value had not yet been read, the block also sets an overrun flag.

A simple read port gives software access to the registers. The register of channel `c` sits at byte offset `4*c`. Reading it returns the result together with both flags, and clears the flags on the clock edge that ends the read. A second view, for a DMA engine, shows the 18-bit contents of any selected channel without side effects. The same view is also readable through the bus at offset 0x100. The per-channel flags are mirrored into two 32-bit vectors indexed by channel number, and each vector is ORed into a summary flag.

Top module: `conv_result_bank`

## Requirements
- R1: A write strobe for an implemented channel `c` (0..15 or 29) loads `res_data` into that channel's result. A read with `rd_en` high at byte address `4*c` returns, in the same cycle, the word {14 zero bits, valid at bit 17, overrun at bit 16, result in bits 15:0}.
- R2: A write strobe for an implemented channel sets its valid flag to 1 on the next clock edge.
- R3: A read of a channel register with no write to that channel in the same cycle clears both its valid and overrun flags on the next clock edge. The data returned shows the values from before the clear.
- R4: A write to a channel whose valid flag is 1 sets its overrun flag. Overrun stays 1 across further writes until the register is read, and overrun is never 1 while valid is 0.
- R5: When a read and a write hit the same channel in the same cycle, the register ends up holding the new result with valid 1 and overrun 0. The read returns the old contents.
- R6: Writes to channel indices other than 0..15 and 29 change nothing. Reads at any other address return 0 and change nothing. This covers unaligned addresses and word offsets 16..28, 30 and 31. When `rd_en` is 0, `rd_data` is 0.
- R7: `valid_vec[c]` and `overrun_vec[c]` equal channel `c`'s flags for c in 0..15 and 29. All other bits are 0.
- R8: `any_valid` is 1 exactly when some valid flag is 1, and `any_overrun` is 1 exactly when some overrun flag is 1.
- R9: `xfer_data` shows {valid, overrun, result} of channel `xfer_chan`, or 0 for an unimplemented index. A bus read at byte offset 0x100 returns this 18-bit value zero-extended to 32 bits. Neither access changes any flag.
- R10: Reset clears every result and every flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_wr | input | 1 | Conversion result strobe |
| res_chan | input | 5 | Channel index of the result |
| res_data | input | 16 | Conversion result value |
| rd_en | input | 1 | Bus read enable |
| rd_addr | input | 9 | Bus read byte address |
| rd_data | output | 32 | Read data, same cycle as `rd_en` |
| xfer_chan | input | 5 | Channel being moved by DMA |
| xfer_data | output | 18 | Side-effect-free view of that channel |
| valid_vec | output | 32 | Valid flags by channel number |
| overrun_vec | output | 32 | Overrun flags by channel number |
| any_valid | output | 1 | OR of all valid flags |
| any_overrun | output | 1 | OR of all overrun flags |

## Verification
Assertions check the per-register flag rules on every cycle: a write sets valid, a lone read clears both flags, an unread write raises overrun, a collision leaves valid set and overrun clear, and an idle register holds. They also check that the decoders select at most one slot, that the reserved vector bits stay at zero, that the summary flags agree with the vectors, and that a DMA-window read leaves the flags alone. Only the bench's sweeps show the channel-to-address map as a whole. These sweeps cover all 32 channel indices, ignored writes to unimplemented indices, stickiness of overrun across several writes, and the exact words returned on reads.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  // Layout of one result register as seen on the bus and the DMA view.
  localparam int RES_W    = 16;
  localparam int OVR_BIT  = RES_W;      // 16
  localparam int VLD_BIT  = RES_W + 1;  // 17
  localparam int VIEW_W   = RES_W + 2;  // 18
  localparam int WORD_W   = 32;
  localparam int CH_W     = 5;

  // Slot s holds external channel s; the final slot holds the internal channel.
  function automatic int slot_to_chan(int s, int n_ext, int int_ch);
    return (s < n_ext) ? s : int_ch;
  endfunction

  // Overrun after a write: cleared if the old data is consumed in the same
  // cycle, otherwise raised when unread data existed, and kept once raised.
  function automatic logic next_overrun(logic vld, logic ovr, logic rd);
    return rd ? 1'b0 : (vld | ovr);
  endfunction

  function automatic logic [VIEW_W-1:0] pack_view(logic vld, logic ovr,
                                                  logic [RES_W-1:0] res);
    return {vld, ovr, res};
  endfunction

  function automatic logic [WORD_W-1:0] widen(logic [VIEW_W-1:0] v);
    return {{(WORD_W-VIEW_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/rbank_slot.sv
module rbank_slot
  import rbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [RES_W-1:0] wr_data,
  output logic [RES_W-1:0] result,
  output logic             valid,
  output logic             overrun
);
  // Named internal events for the assertions.
  logic ovr_event;
  logic collide;
  assign ovr_event = wr_hit & ~rd_hit & valid;
  assign collide   = wr_hit & rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else if (wr_hit) begin
      result  <= wr_data;
      valid   <= 1'b1;
      overrun <= next_overrun(valid, overrun, rd_hit);
    end else if (rd_hit) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> result == $past(wr_data));
  p_write_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> valid);
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && !wr_hit |=> !valid && !overrun);
  p_overrun_on_unread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> overrun);
  p_overrun_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> valid);
  p_collision_r5: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> valid && !overrun);
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit && !rd_hit |=> $stable(result) && $stable(valid) && $stable(overrun));
endmodule

// File: rtl/rbank_decode.sv
module rbank_decode
  import rbank_pkg::*;
#(
  parameter int NUM_EXT_CH = 16,
  parameter int INT_CH     = 29,
  parameter int ADDR_W     = 9,
  parameter int XFER_OFS   = 'h100,
  localparam int NSLOT     = NUM_EXT_CH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_wr,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CH_W-1:0]   xfer_chan,
  output logic [NSLOT-1:0]  wr_hit,
  output logic [NSLOT-1:0]  addr_match,
  output logic [NSLOT-1:0]  rd_hit,
  output logic [NSLOT-1:0]  xfer_match,
  output logic              rd_is_xfer
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_dec
    localparam int CH = slot_to_chan(s, NUM_EXT_CH, INT_CH);
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(CH * 4);
    assign wr_hit[s]     = res_wr && (res_chan == CH_W'(CH));
    assign addr_match[s] = (rd_addr == SLOT_ADDR);
    assign rd_hit[s]     = rd_en && addr_match[s];
    assign xfer_match[s] = (xfer_chan == CH_W'(CH));
  end

  assign rd_is_xfer = (rd_addr == ADDR_W'(XFER_OFS));

  p_wr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
  p_rd_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_match) && !(rd_is_xfer && addr_match != '0));
endmodule

// File: rtl/rbank_aggr.sv
module rbank_aggr
  import rbank_pkg::*;
#(
  parameter int NUM_EXT_CH = 16,
  parameter int INT_CH     = 29,
  localparam int NSLOT     = NUM_EXT_CH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  slot_valid,
  input  logic [NSLOT-1:0]  slot_overrun,
  output logic [WORD_W-1:0] valid_vec,
  output logic [WORD_W-1:0] overrun_vec,
  output logic              any_valid,
  output logic              any_overrun
);
  localparam logic [WORD_W-1:0] IMPL_MASK =
    ((WORD_W'(1) << NUM_EXT_CH) - WORD_W'(1)) | (WORD_W'(1) << INT_CH);

  always_comb begin
    valid_vec   = '0;
    overrun_vec = '0;
    for (int s = 0; s < NSLOT; s++) begin
      valid_vec[slot_to_chan(s, NUM_EXT_CH, INT_CH)]   = slot_valid[s];
      overrun_vec[slot_to_chan(s, NUM_EXT_CH, INT_CH)] = slot_overrun[s];
    end
  end

  assign any_valid   = |slot_valid;
  assign any_overrun = |slot_overrun;

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_vec | overrun_vec) & ~IMPL_MASK) == '0);
  p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_valid == (valid_vec != '0)) && (any_overrun == (overrun_vec != '0)));
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
  import rbank_pkg::*;
#(
  parameter int NUM_EXT_CH = 16,
  parameter int INT_CH     = 29,
  parameter int ADDR_W     = 9,
  parameter int XFER_OFS   = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_wr,
  input  logic [4:0]        res_chan,
  input  logic [15:0]       res_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [4:0]        xfer_chan,
  output logic [17:0]       xfer_data,
  output logic [31:0]       valid_vec,
  output logic [31:0]       overrun_vec,
  output logic              any_valid,
  output logic              any_overrun
);
  localparam int NSLOT = NUM_EXT_CH + 1;

  logic [NSLOT-1:0] wr_hit, addr_match, rd_hit, xfer_match;
  logic             rd_is_xfer;
  logic [NSLOT-1:0] slot_valid, slot_overrun;
  logic [RES_W-1:0] slot_result [NSLOT];
  logic [VIEW_W-1:0] sel_view, xfer_view;

  rbank_decode #(
    .NUM_EXT_CH(NUM_EXT_CH), .INT_CH(INT_CH),
    .ADDR_W(ADDR_W), .XFER_OFS(XFER_OFS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .res_wr(res_wr), .res_chan(res_chan),
    .rd_en(rd_en), .rd_addr(rd_addr), .xfer_chan(xfer_chan),
    .wr_hit(wr_hit), .addr_match(addr_match), .rd_hit(rd_hit),
    .xfer_match(xfer_match), .rd_is_xfer(rd_is_xfer)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    rbank_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit[s]), .rd_hit(rd_hit[s]), .wr_data(res_data),
      .result(slot_result[s]), .valid(slot_valid[s]), .overrun(slot_overrun[s])
    );
  end

  // One-hot selected views: OR of the matching slot, zero when none matches.
  always_comb begin
    sel_view  = '0;
    xfer_view = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (addr_match[s])
        sel_view = sel_view | pack_view(slot_valid[s], slot_overrun[s], slot_result[s]);
      if (xfer_match[s])
        xfer_view = xfer_view | pack_view(slot_valid[s], slot_overrun[s], slot_result[s]);
    end
  end

  assign xfer_data = xfer_view;
  assign rd_data   = !rd_en     ? '0 :
                     rd_is_xfer ? widen(xfer_view) : widen(sel_view);

  rbank_aggr #(.NUM_EXT_CH(NUM_EXT_CH), .INT_CH(INT_CH)) u_aggr (
    .clk(clk), .rst_n(rst_n),
    .slot_valid(slot_valid), .slot_overrun(slot_overrun),
    .valid_vec(valid_vec), .overrun_vec(overrun_vec),
    .any_valid(any_valid), .any_overrun(any_overrun)
  );

  p_xfer_read_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_is_xfer && !res_wr |=> $stable(valid_vec) && $stable(overrun_vec));
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> valid_vec == '0 && overrun_vec == '0 && xfer_data == '0);
endmodule

// File: tb/test_conv_result_bank.sv
module test_conv_result_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_wr = 1'b0;
  logic [4:0]  res_chan = '0;
  logic [15:0] res_data = '0;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [4:0]  xfer_chan = '0;
  logic [17:0] xfer_data;
  logic [31:0] valid_vec, overrun_vec;
  logic        any_valid, any_overrun;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] mres [32];
  logic        mv   [32];
  logic        mo   [32];

  always #4 clk = ~clk;

  conv_result_bank i_conv_result_bank (
    .clk(clk), .rst_n(rst_n), .res_wr(res_wr), .res_chan(res_chan),
    .res_data(res_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .xfer_chan(xfer_chan), .xfer_data(xfer_data), .valid_vec(valid_vec),
    .overrun_vec(overrun_vec), .any_valid(any_valid), .any_overrun(any_overrun)
  );

  function automatic bit impl(int c);
    return (c < 16) || (c == 29);
  endfunction

  function automatic logic [15:0] pat(int c, int k);
    return 16'(c * 16'h0111) ^ 16'hC35A ^ 16'(k * 16'h1F03);
  endfunction

  function automatic logic [17:0] exp_view(int c);
    if (!impl(c)) return '0;
    return {mv[c], mo[c], mres[c]};
  endfunction

  function automatic logic [31:0] exp_read(logic [8:0] a);
    if (a == 9'h100) return {14'b0, exp_view(int'(xfer_chan))};
    if (a[1:0] != 2'b00 || a[8:2] >= 7'd32) return '0;
    return {14'b0, exp_view(int'(a[8:2]))};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 32; c++) begin
      mres[c] = '0; mv[c] = 1'b0; mo[c] = 1'b0;
    end
  endtask

  task automatic check_flags(string tag);
    logic [31:0] ev, eo;
    ev = '0; eo = '0;
    for (int c = 0; c < 32; c++) begin
      if (impl(c)) begin ev[c] = mv[c]; eo[c] = mo[c]; end
    end
    check({tag, "/R7"}, "valid_vec", valid_vec, ev);
    check({tag, "/R7"}, "overrun_vec", overrun_vec, eo);
    check({tag, "/R8"}, "any_valid", {31'b0, any_valid}, {31'b0, ev != 0});
    check({tag, "/R8"}, "any_overrun", {31'b0, any_overrun}, {31'b0, eo != 0});
  endtask

  // Inputs driven 1 ns after a rising edge; combinational read checked 2 ns
  // later; the model advances at the next edge; flags checked after it.
  task automatic step(string tag, logic ws, logic [4:0] wc, logic [15:0] wd,
                      logic re, logic [8:0] ra);
    res_wr = ws; res_chan = wc; res_data = wd; rd_en = re; rd_addr = ra;
    #2;
    if (re) check(tag, "rd_data", rd_data, exp_read(ra));
    else    check({tag, "/R6"}, "rd_data idle", rd_data, '0);
    @(posedge clk);
    for (int c = 0; c < 32; c++) begin
      if (impl(c)) begin
        bit wh, rh;
        wh = ws && (wc == 5'(c));
        rh = re && (ra == 9'(c * 4));
        if (wh) begin
          mo[c] = rh ? 1'b0 : (mv[c] | mo[c]);
          mv[c] = 1'b1;
          mres[c] = wd;
        end else if (rh) begin
          mv[c] = 1'b0; mo[c] = 1'b0;
        end
      end
    end
    #1;
    res_wr = 1'b0; rd_en = 1'b0;
    check_flags(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10: reset state
    check_flags("R10");
    for (int c = 0; c < 32; c++) begin
      xfer_chan = 5'(c); #1;
      check("R10", "xfer_data after reset", {14'b0, xfer_data}, '0);
    end
    @(posedge clk); #1;
    // R1 R2 R6: first write sweep over all 32 indices
    for (int c = 0; c < 32; c++) step("R2", 1'b1, 5'(c), pat(c, 0), 1'b0, '0);
    // R9: DMA view sweep, no side effect
    for (int c = 0; c < 32; c++) begin
      xfer_chan = 5'(c); #1;
      check("R9", "xfer_data", {14'b0, xfer_data}, {14'b0, exp_view(c)});
    end
    // R4: second write sweep raises overrun on every implemented channel
    for (int c = 0; c < 32; c++) step("R4", 1'b1, 5'(c), pat(c, 1), 1'b0, '0);
    // R4: overrun stays set across a further write
    step("R4", 1'b1, 5'd3, 16'hBEEF, 1'b0, '0);
    // R9: read through the DMA window does not clear flags
    xfer_chan = 5'd29;
    step("R9", 1'b0, '0, '0, 1'b1, 9'h100);
    xfer_chan = 5'd20;
    step("R9", 1'b0, '0, '0, 1'b1, 9'h100);
    // R6: unaligned reads return zero and clear nothing
    step("R6", 1'b0, '0, '0, 1'b1, 9'h006);
    step("R6", 1'b0, '0, '0, 1'b1, 9'h075);
    // R1 R3 R6: read every word address 0..31, flags cleared afterwards
    for (int w = 0; w < 32; w++) step("R3", 1'b0, '0, '0, 1'b1, 9'(w * 4));
    // R3: second read returns result with flags clear
    step("R1", 1'b0, '0, '0, 1'b1, 9'h074);
    // R5: collision on channel 7 after an overrun
    step("R5", 1'b1, 5'd7, 16'h1111, 1'b0, '0);
    step("R5", 1'b1, 5'd7, 16'h2222, 1'b0, '0);
    step("R5", 1'b1, 5'd7, 16'h3333, 1'b1, 9'h01C);
    step("R5", 1'b0, '0, '0, 1'b1, 9'h01C);
    // R5: collision on a fresh channel 29
    step("R5", 1'b1, 5'd29, 16'hA5A5, 1'b1, 9'h074);
    // R3: read of one channel while another is written
    step("R3", 1'b1, 5'd12, 16'h0F0F, 1'b1, 9'h074);
    // R10: mid-run reset clears everything
    step("R10", 1'b1, 5'd12, 16'h7777, 1'b0, '0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_reset();
    check_flags("R10");
    for (int w = 0; w < 32; w++) step("R10", 1'b0, '0, '0, 1'b1, 9'(w * 4));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule